// File: doc/BRIEF.md
# Multiplexed Display RAM Loader

This block takes display data one byte at a time and places its bits into a small display memory of 24 words by 4 bits. Each word feeds one segment driver, and bit n of a word is the value shown while backplane n is active. A display scanner reads the memory through a combinational port. How the eight bits of a byte spread over words and bit positions depends on the drive mode: static, 1:2, 1:3 or 1:4 multiplex.

A write pointer chooses the first word a byte lands in. After every byte the pointer moves on by the number of words that byte covered. Several of these blocks can share one data stream. Each block holds a 3-bit device counter and compares it with its strapped address pins, and it stores data only while the two match. When the pointer runs past the last word it wraps and the device counter steps. The rest of a stream, even the rest of a single byte, then goes to the next block in the chain.

Top module: `segload_top`

## Requirements
- R1: Reset (active-low `rstN`) clears every memory word to 0, sets the pointer to 0 and sets the device counter to 0.
- R2: `scanWord` is the word at `scanAddr` combinationally, with bit n belonging to backplane n. An address of 24 or more reads as 0.
- R3: Static mode (`driveMode` = 0): bit 7 down to bit 0 of the byte go into bit 0 of eight consecutive words, bit 7 into the lowest word. The other bits of those words keep their values.
- R4: 1:2 mode (`driveMode` = 1): the byte fills bits 0 and 1 of four consecutive words. The byte is taken MSB first and fills bit 0 before bit 1 in each word. Bits 2 and 3 keep their values.
- R5: 1:3 mode (`driveMode` = 2): the byte fills bits 0 to 2 of three words in the same order. Bit 2 of the third word and bit 3 of every word keep their values.
- R6: 1:4 mode (`driveMode` = 3): the byte fills bits 0 to 3 of two words in the same order. Byte bit 7 goes to bit 0 of the first word, and byte bit 0 goes to bit 3 of the second word.
- R7: A byte moves the pointer on by 8, 4, 3 or 2 words in modes 0 to 3. A pointer load (`loadPtr`) with a value from 0 to 23 sets the pointer. A load with a larger value leaves the pointer unchanged.
- R8: A word is written only while the device counter that applies to that word equals `hwAddr`. A suppressed byte still moves the pointer.
- R9: A device-select (`devSel`) loads the device counter. When a byte carries the pointer past word 23, the pointer continues from word 0 and the counter increments modulo 8, so 7 goes to 0.
- R10: When a byte crosses word 23, the words beyond the wrap (from word 0 on) are checked against the incremented counter and the words up to 23 against the current one, so one byte can be partly written and partly suppressed.
- R11: The memory changes only on byte strobes. A byte strobed in one cycle is visible on `scanWord` right after the rising edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Data byte strobe, one byte per cycle |
| byteData | input | 8 | Display data byte |
| loadPtr | input | 1 | Pointer load command strobe |
| ptrValue | input | 5 | Pointer value for a load |
| devSel | input | 1 | Device counter load command strobe |
| devValue | input | 3 | Device counter value for a load |
| driveMode | input | 2 | 0 static, 1 = 1:2, 2 = 1:3, 3 = 1:4 |
| hwAddr | input | 3 | Strapped device address |
| scanAddr | input | 5 | Scan read address (segment) |
| scanWord | output | 4 | Word at the scan address, one bit per backplane |

## Verification
A byte or command is driven at a falling edge and captured at the next rising edge. Its memory effect is on `scanWord` one register stage later, so the bench reads the port after the following falling edge with the read address already settled. Reads are combinational: the bench sets `scanAddr`, waits a small delay and compares. The pointer and device counter have no port. The bench observes them through where the next byte lands and whether it is stored, and always compares after the byte that exposes them.

// File: rtl/segload_pkg.sv
package segload_pkg;
  localparam int RAM_DEPTH = 24;
  localparam int BP_COUNT  = 4;
  localparam int BYTE_W    = 8;
  localparam int SUB_W     = 3;
  localparam int ADDR_W    = $clog2(RAM_DEPTH);
  localparam int SLOTS     = BYTE_W;
  localparam int BIDX_W    = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MUX2   = 2'd1,
    MODE_MUX3   = 2'd2,
    MODE_MUX4   = 2'd3
  } driveMode_e;

  typedef struct packed {
    logic [SLOTS-1:0]             slotWr;
    logic [SLOTS-1:0][ADDR_W-1:0] slotAddr;
  } wrStrobe_t;

  function automatic int bitsPerWord(input logic [1:0] m);
    return int'(m) + 1;
  endfunction

  function automatic int wordsPerByte(input logic [1:0] m);
    return (BYTE_W + int'(m)) / (int'(m) + 1);
  endfunction
endpackage

// File: rtl/segload_ctrl.sv
module segload_ctrl
  import segload_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              loadPtr,
  input  logic [ADDR_W-1:0] ptrValue,
  input  logic              devSel,
  input  logic [SUB_W-1:0]  devValue,
  input  logic [1:0]        driveMode,
  input  logic [SUB_W-1:0]  hwAddr,
  output wrStrobe_t         strobe
);
  localparam logic [ADDR_W:0] DEPTH_X = (ADDR_W+1)'(RAM_DEPTH);

  logic [ADDR_W-1:0] ptrQ;
  logic [SUB_W-1:0]  subQ;
  logic [ADDR_W:0]   stepW;
  logic [ADDR_W:0]   sumW;
  logic              overflow;
  logic [ADDR_W-1:0] nextPtr;
  logic [SLOTS-1:0]  wrVec;
  logic [ADDR_W-1:0] addrVec [SLOTS];

  assign stepW = (ADDR_W+1)'(wordsPerByte(driveMode));

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    logic [ADDR_W:0]  rawAddr;
    logic             wrapped;
    logic [SUB_W-1:0] slotSub;
    assign rawAddr    = {1'b0, ptrQ} + (ADDR_W+1)'(j);
    assign wrapped    = rawAddr >= DEPTH_X;
    assign slotSub    = subQ + SUB_W'(wrapped);
    assign addrVec[j] = wrapped ? ADDR_W'(rawAddr - DEPTH_X) : rawAddr[ADDR_W-1:0];
    assign wrVec[j]   = byteValid && ((ADDR_W+1)'(j) < stepW) && (slotSub == hwAddr);
  end

  always_comb begin
    strobe.slotWr = wrVec;
    for (int j = 0; j < SLOTS; j++) strobe.slotAddr[j] = addrVec[j];
  end

  always_comb begin
    sumW     = {1'b0, ptrQ} + stepW;
    overflow = sumW >= DEPTH_X;
    nextPtr  = overflow ? ADDR_W'(sumW - DEPTH_X) : sumW[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      subQ <= '0;
    end else begin
      if (loadPtr) begin
        if ({1'b0, ptrValue} < DEPTH_X) ptrQ <= ptrValue;
      end else if (byteValid) begin
        ptrQ <= nextPtr;
        if (overflow) subQ <= subQ + 1'b1;
      end
      if (devSel) subQ <= devValue;
    end
  end

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, ptrQ} < DEPTH_X);

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !loadPtr) |=> $stable(ptrQ));

  // R9
  sub_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !devSel && !loadPtr) |=> ((subQ != $past(subQ)) == (ptrQ < $past(ptrQ))));

  // R8
  slot_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(strobe.slotWr) <= int'(stepW)));

  // R11
  idle_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> (strobe.slotWr == '0));
endmodule

// File: rtl/segload_ram.sv
module segload_ram
  import segload_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strobe,
  input  logic [BYTE_W-1:0]   byteData,
  input  logic [1:0]          driveMode,
  input  logic [ADDR_W-1:0]   scanAddr,
  output logic [BP_COUNT-1:0] scanWord
);
  localparam logic [ADDR_W:0] DEPTH_X = (ADDR_W+1)'(RAM_DEPTH);

  logic [RAM_DEPTH-1:0][BP_COUNT-1:0] ramFlat;
  logic [BP_COUNT-1:0] laneMask [SLOTS];
  logic [BP_COUNT-1:0] laneBits [SLOTS];

  always_comb begin
    int perWord;
    int srcPos;
    logic [BIDX_W-1:0] srcIdx;
    perWord = bitsPerWord(driveMode);
    for (int j = 0; j < SLOTS; j++) begin
      laneMask[j] = '0;
      laneBits[j] = '0;
      for (int p = 0; p < BP_COUNT; p++) begin
        srcPos = j * perWord + p;
        srcIdx = BIDX_W'(BYTE_W - 1 - srcPos);
        if (p < perWord && srcPos < BYTE_W) begin
          laneMask[j][p] = 1'b1;
          laneBits[j][p] = byteData[srcIdx];
        end
      end
    end
  end

  for (genvar a = 0; a < RAM_DEPTH; a++) begin : g_row
    logic [BP_COUNT-1:0] rowQ;
    logic [BP_COUNT-1:0] rowMask;
    logic [BP_COUNT-1:0] rowBits;
    always_comb begin
      rowMask = '0;
      rowBits = '0;
      for (int j = 0; j < SLOTS; j++) begin
        if (strobe.slotWr[j] && strobe.slotAddr[j] == ADDR_W'(a)) begin
          rowMask = rowMask | laneMask[j];
          rowBits = rowBits | laneBits[j];
        end
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rowQ <= '0;
      else       rowQ <= (rowQ & ~rowMask) | (rowBits & rowMask);
    end
    assign ramFlat[a] = rowQ;
  end

  assign scanWord = ({1'b0, scanAddr} < DEPTH_X) ? ramFlat[scanAddr] : '0;

  logic keepSel;
  assign keepSel = ramFlat[strobe.slotAddr[2]][2];

  // R11
  ram_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.slotWr == '0) |=> $stable(ramFlat));

  // R5
  keep_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveMode == MODE_MUX3 && strobe.slotWr[2]) |=>
      (ramFlat[$past(strobe.slotAddr[2])][2] == $past(keepSel)));
endmodule

// File: rtl/segload_top.sv
module segload_top
  import segload_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteData,
  input  logic                loadPtr,
  input  logic [ADDR_W-1:0]   ptrValue,
  input  logic                devSel,
  input  logic [SUB_W-1:0]    devValue,
  input  logic [1:0]          driveMode,
  input  logic [SUB_W-1:0]    hwAddr,
  input  logic [ADDR_W-1:0]   scanAddr,
  output logic [BP_COUNT-1:0] scanWord
);
  wrStrobe_t strobe;

  segload_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .loadPtr(loadPtr),
    .ptrValue(ptrValue), .devSel(devSel), .devValue(devValue),
    .driveMode(driveMode), .hwAddr(hwAddr), .strobe(strobe)
  );

  segload_ram ram_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .driveMode(driveMode), .scanAddr(scanAddr), .scanWord(scanWord)
  );
endmodule

// File: tb/segload_top_tb.sv
module segload_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       byteValid, loadPtr, devSel;
  logic [7:0] byteData;
  logic [4:0] ptrValue, scanAddr;
  logic [2:0] devValue, hwAddr;
  logic [1:0] driveMode;
  logic [3:0] scanWord;

  int checks = 0;
  int fails  = 0;

  logic [3:0] mdl [24];
  int mPtr, mSub;

  // rows: {mode[1:0], spare, ptr[4:0], data[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {2'd0, 1'b0, 5'd0,  8'hA5},
    {2'd1, 1'b0, 5'd3,  8'h3C},
    {2'd2, 1'b0, 5'd9,  8'hE7},
    {2'd3, 1'b0, 5'd15, 8'h96},
    {2'd1, 1'b0, 5'd22, 8'hFF},
    {2'd3, 1'b0, 5'd23, 8'h5A},
    {2'd2, 1'b0, 5'd5,  8'h81},
    {2'd0, 1'b0, 5'd17, 8'h0F}
  };

  segload_top dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .loadPtr(loadPtr), .ptrValue(ptrValue), .devSel(devSel), .devValue(devValue),
    .driveMode(driveMode), .hwAddr(hwAddr), .scanAddr(scanAddr), .scanWord(scanWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finishRun();
  end

  task automatic modelReset();
    for (int a = 0; a < 24; a++) mdl[a] = 4'h0;
    mPtr = 0; mSub = 0;
  endtask

  task automatic modelByte(input int m, input logic [7:0] d);
    int per, step, a, s;
    per  = m + 1;
    step = (m == 0) ? 8 : (m == 1) ? 4 : (m == 2) ? 3 : 2;
    for (int k = 0; k < 8; k++) begin
      a = mPtr + k / per;
      s = mSub;
      if (a >= 24) begin a = a - 24; s = (s + 1) % 8; end
      if (s == int'(hwAddr)) mdl[a][k % per] = d[7 - k];
    end
    mPtr = mPtr + step;
    if (mPtr >= 24) begin mPtr = mPtr - 24; mSub = (mSub + 1) % 8; end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic sendByte(input logic [1:0] m, input logic [7:0] d);
    @(negedge clk);
    driveMode = m; byteData = d; byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    modelByte(int'(m), d);
  endtask

  task automatic loadPointer(input logic [4:0] v);
    @(negedge clk);
    loadPtr = 1'b1; ptrValue = v;
    @(negedge clk);
    loadPtr = 1'b0;
    if (v < 24) mPtr = int'(v);
  endtask

  task automatic selectDev(input logic [2:0] v);
    @(negedge clk);
    devSel = 1'b1; devValue = v;
    @(negedge clk);
    devSel = 1'b0;
    mSub = int'(v);
  endtask

  task automatic checkWord(input logic [4:0] a, input logic [3:0] exp, input string req);
    scanAddr = a;
    #1;
    checks++;
    if (scanWord !== exp) begin
      fails++;
      $display("FAIL %s: addr %0d actual=%b expected=%b", req, a, scanWord, exp);
    end
  endtask

  task automatic checkAll(input string req);
    int bad;
    bad = 0;
    for (int a = 0; a < 24; a++) begin
      scanAddr = 5'(a);
      #1;
      if (scanWord !== mdl[a]) begin
        if (bad == 0)
          $display("FAIL %s: addr %0d actual=%b expected=%b", req, a, scanWord, mdl[a]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    rstN = 1'b0; byteValid = 1'b0; loadPtr = 1'b0; devSel = 1'b0;
    byteData = '0; ptrValue = '0; devValue = '0; driveMode = '0;
    hwAddr = '0; scanAddr = '0;
    applyReset();

    // R1 reset state of the whole memory
    checkAll("R1");

    // table walk: R3 R4 R5 R6 R7 R8 R10 against the bench model
    for (int i = 0; i < 8; i++) begin
      selectDev(3'd0);
      loadPointer(VEC[i][12:8]);
      sendByte(VEC[i][15:14], VEC[i][7:0]);
      checkAll("R3/R4/R5/R6/R10 table");
    end

    // directed tests from a fresh reset
    applyReset();
    checkWord(5'd0, 4'b0000, "R1");

    // R3 static fill, MSB into lowest word
    sendByte(2'd0, 8'hA5);
    checkWord(5'd0, 4'b0001, "R3");
    checkWord(5'd1, 4'b0000, "R3");
    checkWord(5'd7, 4'b0001, "R3");
    // R7 pointer moved by 8
    sendByte(2'd0, 8'h80);
    checkWord(5'd8, 4'b0001, "R7");
    // R7 out-of-range load ignored: pointer stays at 16
    loadPointer(5'd30);
    sendByte(2'd0, 8'h80);
    checkWord(5'd16, 4'b0001, "R7");

    // R6 1:4 fill
    selectDev(3'd0);
    loadPointer(5'd12);
    sendByte(2'd3, 8'h20);
    checkWord(5'd12, 4'b0100, "R6");
    loadPointer(5'd14);
    sendByte(2'd3, 8'hC3);
    checkWord(5'd14, 4'b0011, "R6");
    checkWord(5'd15, 4'b1100, "R6");

    // R5 1:3 fill keeps bit 2 of the third word
    loadPointer(5'd10);
    sendByte(2'd2, 8'h00);
    checkWord(5'd12, 4'b0100, "R5");
    loadPointer(5'd10);
    sendByte(2'd2, 8'hFF);
    checkWord(5'd10, 4'b0111, "R5");
    checkWord(5'd12, 4'b0111, "R5");
    // R7 pointer moved by 3
    sendByte(2'd2, 8'h00);
    checkWord(5'd14, 4'b0000, "R7");
    checkWord(5'd15, 4'b1100, "R5");

    // R4 1:2 fill
    loadPointer(5'd18);
    sendByte(2'd1, 8'hB4);
    checkWord(5'd18, 4'b0001, "R4");
    checkWord(5'd19, 4'b0011, "R4");
    checkWord(5'd20, 4'b0010, "R4");
    sendByte(2'd1, 8'hC0);
    checkWord(5'd22, 4'b0011, "R7");

    // R8 mismatch suppresses but still advances
    hwAddr = 3'd5;
    selectDev(3'd4);
    loadPointer(5'd16);
    sendByte(2'd0, 8'hFF);
    checkWord(5'd17, 4'b0000, "R8");
    sendByte(2'd0, 8'h00);
    checkWord(5'd0, 4'b0000, "R8");

    // R10 overflow inside one byte, R9 counter 7 wraps to 0
    hwAddr = 3'd0;
    selectDev(3'd7);
    loadPointer(5'd22);
    sendByte(2'd0, 8'hFF);
    checkWord(5'd22, 4'b0011, "R10");
    checkWord(5'd23, 4'b0000, "R10");
    checkWord(5'd0, 4'b0001, "R10");
    checkWord(5'd5, 4'b0001, "R10");
    checkWord(5'd6, 4'b0000, "R10");
    sendByte(2'd0, 8'h80);
    checkWord(5'd6, 4'b0001, "R9");

    // R11 idle cycles leave memory alone
    repeat (5) @(negedge clk);
    checkWord(5'd6, 4'b0001, "R11");

    // R2 out-of-range scan reads zero
    checkWord(5'd25, 4'b0000, "R2");

    // R1 reset clears written words
    applyReset();
    checkWord(5'd6, 4'b0000, "R1");

    finishRun();
  end
endmodule